// File: doc/BRIEF.md
# Radio-State Control Table Selector

This block sits between the transmit/receive state lines of a two-channel RF front end and the parts that set its attenuators, RF switches and port LEDs. Each channel supplies two state pins. Their level says whether the channel is idle, receiving, transmitting or in full duplex. The block turns those pins into an index and looks up, for each channel, an attenuation code and an RF control word. Both come from small tables that software fills through a simple register write/read port.

Every channel and every table group (attenuation, or RF switch plus LED) has its own index-source selector. In the classic source a channel follows its own two pins, so the control outputs track radio state without any register traffic. In the software source the pins are ignored and a per-channel index register is used. In the combined source the four pins of both channels together form one 4-bit index, which opens all sixteen table entries. Outputs are registered.

Top module: `atr_table_sel`

## Requirements
- R1: While reset is held, and on the first cycle after it ends, every table entry, both software index registers and every output are zero. Zero means maximum attenuation and all LEDs off.
- R2: In the classic source (mode code 00, and also 11) channel c uses the index {2'b00, atr_pins[2c+1:2c]}. Pin bit 1 flags TX active and pin bit 0 flags RX active, so idle, receive, transmit and full duplex select entries 0, 1, 2 and 3. Transmit-only therefore selects entry 2.
- R3: In the software source (mode code 01) channel c uses the low four bits of its index register at address 7'h40+c. Changes on atr_pins have no effect on that channel's outputs.
- R4: In the combined source (mode code 10) the index is {atr_pins[3:2], atr_pins[1:0]}: channel 1's pins are the upper half and channel 0's pins are the lower half.
- R5: dsa_mode[2c+1:2c] selects the source for channel c's attenuation table, and rf_mode[2c+1:2c] selects it for channel c's RF/LED table. All four selections act independently.
- R6: An index change seen at one rising clock edge appears on dsa_code, sw_ctl and led after that edge, and not before it.
- R7: Register map. When reg_addr[6]=0 the address picks a table entry: reg_addr[5] selects the group (0 attenuation, 1 RF/LED), reg_addr[4] selects the channel and reg_addr[3:0] selects the entry. Addresses 7'h40 and 7'h41 are the channel 0 and channel 1 index registers. reg_rdata returns the addressed content zero-extended, with no read delay.
- R8: An RF/LED entry holds the switch bits in [RF_W-1:0] and the LEDs in [RF_W+2:RF_W]. The LED bits are TX/RX-port green, TX/RX-port red and RX-port green, in that order from the low bit. led[3c+2:3c] carries them. When an entry sets both green and red for the TX/RX port, red wins and green is shown off.
- R9: If a write to the active entry and a change of index land on the same edge, the output first shows the old content of the new index. The written value appears one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| atr_pins | input | 4 | Radio-state pins, [1:0] channel 0, [3:2] channel 1 |
| dsa_mode | input | 4 | Index source of the attenuation tables, 2 bits per channel |
| rf_mode | input | 4 | Index source of the RF/LED tables, 2 bits per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| dsa_code | output | 2*DSA_W | Attenuation codes, channel 0 in the low half |
| sw_ctl | output | 2*RF_W | RF switch words, channel 0 in the low half |
| led | output | 6 | LED drives, 3 bits per channel |

## Verification
A table write and an index change can hit the same clock edge, and they can hit the very entry that becomes active. The bench provokes this by moving channel 0's pins from transmit to receive while it rewrites the receive entry in the same cycle. It then expects the old receive content one edge later and the new content on the edge after that. A related overlap is a pin change that arrives while a channel reads its software index register. There the bench toggles all pins and requires the affected outputs to stay fixed, while the channels still on the classic source follow the pins.

// File: rtl/atr_table_sel.sv
module atr_table_sel #(
  parameter int DSA_W  = 16,
  parameter int RF_W   = 8,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          atr_pins,
  input  logic [3:0]          dsa_mode,
  input  logic [3:0]          rf_mode,
  input  logic                reg_we,
  input  logic [6:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [2*DSA_W-1:0]  dsa_code,
  output logic [2*RF_W-1:0]   sw_ctl,
  output logic [5:0]          led
);
  localparam int N_CH  = 2;
  localparam int N_ENT = 16;
  localparam int IDX_W = $clog2(N_ENT);
  localparam int LED_W = 3;
  localparam int RFE_W = RF_W + LED_W;

  logic [DSA_W-1:0] dsa_tab [N_CH][N_ENT];
  logic [RFE_W-1:0] rf_tab  [N_CH][N_ENT];
  logic [IDX_W-1:0] sw_idx  [N_CH];

  logic [DSA_W-1:0] dsa_q [N_CH];
  logic [RF_W-1:0]  sw_q  [N_CH];
  logic [LED_W-1:0] led_q [N_CH];

  wire             is_cfg = reg_addr[6];
  wire             grp    = reg_addr[5];
  wire             wch    = reg_addr[4];
  wire [IDX_W-1:0] went   = reg_addr[IDX_W-1:0];

  function automatic logic [IDX_W-1:0] pick(input logic [1:0] m, input logic [1:0] own,
                                           input logic [IDX_W-1:0] sw, input logic [3:0] pins);
    case (m)
      2'b01:   return sw;
      2'b10:   return pins;
      default: return {2'b00, own};
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < N_CH; c++) begin
        sw_idx[c] <= '0;
        for (int e = 0; e < N_ENT; e++) begin
          dsa_tab[c][e] <= '0;
          rf_tab[c][e]  <= '0;
        end
      end
    end else if (reg_we) begin
      if (is_cfg)
        sw_idx[reg_addr[0]] <= reg_wdata[IDX_W-1:0];
      else if (grp)
        rf_tab[wch][went] <= reg_wdata[RFE_W-1:0];
      else
        dsa_tab[wch][went] <= reg_wdata[DSA_W-1:0];
    end
  end

  always_comb begin
    if (is_cfg)   reg_rdata = DATA_W'(sw_idx[reg_addr[0]]);
    else if (grp) reg_rdata = DATA_W'(rf_tab[wch][went]);
    else          reg_rdata = DATA_W'(dsa_tab[wch][went]);
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [IDX_W-1:0] d_idx, r_idx;
    logic [RFE_W-1:0] r_ent;
    assign d_idx = pick(dsa_mode[2*c+:2], atr_pins[2*c+:2], sw_idx[c], atr_pins);
    assign r_idx = pick(rf_mode[2*c+:2],  atr_pins[2*c+:2], sw_idx[c], atr_pins);
    assign r_ent = rf_tab[c][r_idx];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dsa_q[c] <= '0;
        sw_q[c]  <= '0;
        led_q[c] <= '0;
      end else begin
        dsa_q[c] <= dsa_tab[c][d_idx];
        sw_q[c]  <= r_ent[RF_W-1:0];
        led_q[c] <= {r_ent[RF_W+2], r_ent[RF_W+1], r_ent[RF_W] & ~r_ent[RF_W+1]};
      end
    end

    assign dsa_code[c*DSA_W+:DSA_W] = dsa_q[c];
    assign sw_ctl[c*RF_W+:RF_W]     = sw_q[c];
    assign led[c*LED_W+:LED_W]      = led_q[c];
  end
endmodule

// File: rtl/atr_table_sel_chk.sv
module atr_table_sel_chk #(
  parameter int DSA_W  = 16,
  parameter int RF_W   = 8,
  parameter int DATA_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [3:0]         dsa_mode,
  input logic [3:0]         rf_mode,
  input logic               reg_we,
  input logic [6:0]         reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [2*DSA_W-1:0] dsa_code,
  input logic [2*RF_W-1:0]  sw_ctl,
  input logic [5:0]         led
);
  localparam int RFE_W = RF_W + 3;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (dsa_code == '0 && sw_ctl == '0 && led == '0));

  // R3
  sw_ignores_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsa_mode[1:0] == 2'b01 && $past(dsa_mode[1:0]) == 2'b01 && !$past(reg_we))
    |=> $stable(dsa_code[DSA_W-1:0]));

  // R3
  sw_ignores_pins_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_mode[3:2] == 2'b01 && $past(rf_mode[3:2]) == 2'b01 && !$past(reg_we))
    |=> ($stable(sw_ctl[2*RF_W-1:RF_W]) && $stable(led[5:3])));

  // R7
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_we) && !$past(reg_addr[6]) && reg_addr == $past(reg_addr))
    |-> reg_rdata == ($past(reg_addr[5]) ? DATA_W'($past(reg_wdata[RFE_W-1:0]))
                                         : DATA_W'($past(reg_wdata[DSA_W-1:0]))));

  // R8
  led_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(led[0] && led[1]) && !(led[3] && led[4]));
endmodule

bind atr_table_sel atr_table_sel_chk #(.DSA_W(DSA_W), .RF_W(RF_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dsa_mode(dsa_mode), .rf_mode(rf_mode),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .dsa_code(dsa_code), .sw_ctl(sw_ctl), .led(led)
);

// File: tb/atr_table_sel_bench.sv
module atr_table_sel_bench;
  localparam int DSA_W = 16, RF_W = 8, DATA_W = 16;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [3:0] atr_pins = 0, dsa_mode = 0, rf_mode = 0;
  logic [6:0] reg_addr = 0;
  logic [DATA_W-1:0] reg_wdata = 0, reg_rdata;
  logic [2*DSA_W-1:0] dsa_code;
  logic [2*RF_W-1:0] sw_ctl;
  logic [5:0] led;
  int checks = 0, errors = 0;
  bit done = 0;

  atr_table_sel #(.DSA_W(DSA_W), .RF_W(RF_W), .DATA_W(DATA_W)) u_atr_table_sel (.*);

  always #5 clk = ~clk;

  function automatic logic [15:0] dsa_v(int c, int e); return 16'hA000 | 16'(c << 8) | 16'(e); endfunction
  function automatic logic [7:0] sw_v(int c, int e); return 8'(32 + c * 64 + e); endfunction
  function automatic logic [2:0] led_raw(int e);
    case (e) 0: return 3'b000; 1: return 3'b101; 2: return 3'b010; 3: return 3'b111; default: return 3'b011; endcase
  endfunction
  function automatic logic [2:0] led_exp(int e);
    logic [2:0] r = led_raw(e);
    return {r[2], r[1], r[0] & ~r[1]};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(logic [6:0] a, logic [15:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic chk_ch(string req, int c, int de, int re);
    check(req, $sformatf("dsa ch%0d", c), 32'(dsa_code[c*DSA_W+:DSA_W]), 32'(dsa_v(c, de)));
    check(req, $sformatf("sw ch%0d", c), 32'(sw_ctl[c*RF_W+:RF_W]), 32'(sw_v(c, re)));
    check(req, $sformatf("led ch%0d", c), 32'(led[c*3+:3]), 32'(led_exp(re)));
  endtask

  task automatic t_reset();
    check("R1", "dsa after reset", 32'(dsa_code), 0);
    check("R1", "sw after reset", 32'(sw_ctl), 0);
    check("R1", "led after reset", 32'(led), 0);
    reg_addr = 7'h40; #1 check("R1", "index reg 0", 32'(reg_rdata), 0);
    reg_addr = 7'h3F; #1 check("R1", "rf entry ch1 15", 32'(reg_rdata), 0);
  endtask

  task automatic t_load();
    for (int c = 0; c < 2; c++)
      for (int e = 0; e < 16; e++) begin
        wr(7'(c * 16 + e), dsa_v(c, e));
        wr(7'(32 + c * 16 + e), {5'b0, led_raw(e), sw_v(c, e)});
      end
    reg_addr = 7'h17; #1 check("R7", "readback dsa ch1 7", 32'(reg_rdata), 32'(dsa_v(1, 7)));
    reg_addr = 7'h2C; #1 check("R7", "readback rf ch0 12", 32'(reg_rdata), 32'({5'b0, led_raw(12), sw_v(0, 12)}));
  endtask

  task automatic t_classic();
    dsa_mode = 0; rf_mode = 0;
    for (int s = 0; s < 4; s++) begin
      atr_pins = 4'((3 - s) << 2 | s);
      step();
      chk_ch("R2", 0, s, s);
      chk_ch("R2", 1, 3 - s, 3 - s);
    end
    atr_pins = 4'b0010; step();
    check("R2", "tx-only selects entry 2", 32'(dsa_code[15:0]), 32'(dsa_v(0, 2)));
    dsa_mode = 4'b1111; rf_mode = 4'b1111; atr_pins = 4'b0110; step();
    chk_ch("R2", 0, 2, 2); chk_ch("R2", 1, 1, 1);
    dsa_mode = 0; rf_mode = 0;
  endtask

  task automatic t_latency();
    atr_pins = 4'b0000; step();
    atr_pins = 4'b0011; #2;
    check("R6", "dsa before edge", 32'(dsa_code[15:0]), 32'(dsa_v(0, 0)));
    @(negedge clk);
    check("R6", "dsa after edge", 32'(dsa_code[15:0]), 32'(dsa_v(0, 3)));
    check("R8", "red overrides green", 32'(led[2:0]), 32'(3'b110));
  endtask

  task automatic t_software();
    wr(7'h40, 16'h0009); wr(7'h41, 16'hFFF5);
    reg_addr = 7'h41; #1 check("R7", "index reg 1 readback", 32'(reg_rdata), 32'h5);
    dsa_mode = 4'b0101; rf_mode = 4'b0100;
    for (int p = 0; p < 4; p++) begin
      atr_pins = 4'(p * 5);
      step();
      check("R3", "ch0 dsa from index reg", 32'(dsa_code[15:0]), 32'(dsa_v(0, 9)));
      check("R3", "ch1 dsa from index reg", 32'(dsa_code[31:16]), 32'(dsa_v(1, 5)));
      chk_ch("R3", 1, 5, 5);
      check("R5", "ch0 rf still classic", 32'(sw_ctl[7:0]), 32'(sw_v(0, p & 3)));
    end
  endtask

  task automatic t_combined();
    dsa_mode = 4'b1010; rf_mode = 4'b1010; atr_pins = 4'b1001; step();
    chk_ch("R4", 0, 9, 9); chk_ch("R4", 1, 9, 9);
    atr_pins = 4'b0111; step();
    chk_ch("R4", 0, 7, 7); chk_ch("R4", 1, 7, 7);
  endtask

  task automatic t_mixed();
    dsa_mode = 4'b0010; rf_mode = 4'b1001; atr_pins = 4'b1110; step();
    check("R5", "ch0 dsa combined", 32'(dsa_code[15:0]), 32'(dsa_v(0, 14)));
    check("R5", "ch1 dsa classic", 32'(dsa_code[31:16]), 32'(dsa_v(1, 3)));
    check("R5", "ch0 rf software", 32'(sw_ctl[7:0]), 32'(sw_v(0, 9)));
    check("R5", "ch1 rf combined", 32'(sw_ctl[15:8]), 32'(sw_v(1, 14)));
  endtask

  task automatic t_same_cycle();
    dsa_mode = 0; rf_mode = 0; atr_pins = 4'b0010; step();
    atr_pins = 4'b0001; reg_we = 1; reg_addr = 7'h01; reg_wdata = 16'h5A5A;
    @(negedge clk); reg_we = 0;
    check("R9", "old content of new index", 32'(dsa_code[15:0]), 32'(dsa_v(0, 1)));
    step();
    check("R9", "written value one edge later", 32'(dsa_code[15:0]), 32'h5A5A);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load();
    t_classic();
    t_latency();
    t_software();
    t_combined();
    t_mixed();
    t_same_cycle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule